// File: doc/BRIEF.md
# Serial-Loaded Mapper Register File

This block collects processor writes aimed at the upper half of a 16-bit address space and builds 5-bit control values from them. Each accepted write contributes one bit, taken from data bit 0. The first bit becomes the least significant bit of the value. After five such writes, the assembled value is stored in one of four control registers. Address bits 14:13 of the fifth write choose which register.

A partial load is thrown away in two cases. The first is a write with data bit 7 set. The second is a write whose register-select bits differ from those of the previous accepted write.

The block always presents all four register values. When a value is committed, it raises a one-clock update pulse together with the index of the register written. From register 0 bits 1:0 it also decodes a 2-bit nametable mirroring code. Logic elsewhere translates banks from these outputs.

Top module: `serial_mapper_regs`

## Requirements
- R1: While reset is high and right after it falls, register 0 reads 0x0C, registers 1 to 3 read 0, the mirroring code is 3 and the update pulse is low. The bit count and the partial value are also cleared.
- R2: A write is accepted only in a clock cycle where `wr_stb` is high and `wr_addr[15]` is 1. Other cycles change no register, raise no pulse, and leave a partial load untouched.
- R3: On an accepted write, `wr_data[0]` becomes bit k of the value being built, where k is the number of bits already collected (0 to 4). The value therefore fills from the least significant bit upward.
- R4: The fifth collected bit stores the full 5-bit value into register `wr_addr[14:13]` of that write. The count and the partial value then return to zero.
- R5: An accepted write with `wr_data[7]` = 1 clears the count and the partial value and commits nothing. Its other data bits have no effect.
- R6: On every accepted write, including one with bit 7 set, the select bits `wr_addr[14:13]` are remembered. An accepted write whose select bits differ from the remembered ones first discards the count and the partial value, then collects its own bit as bit 0. After reset the remembered select is 0.
- R7: `upd_pulse` is high for exactly the one clock after the commit edge, and `upd_index` then carries the register number. At all other times the pulse is low.
- R8: `mirror_code` follows register 0 bits 1:0: 11 gives 0 (two-screen horizontal), 10 gives 1 (two-screen vertical), 01 gives 2 (single-screen upper) and 00 gives 3 (single-screen lower).
- R9: `reg_vec` holds register i at bits [5i+4:5i]. A commit changes only the register it targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Single-cycle write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data (bit 0 serial data, bit 7 abort) |
| reg_vec | output | 20 | All four 5-bit registers, register i at [5i+4:5i] |
| upd_pulse | output | 1 | One-clock commit indication |
| upd_index | output | 2 | Index of the register just committed |
| mirror_code | output | 2 | Decoded mirroring arrangement |

## Verification
A write is sampled on the rising edge where the strobe is high. The committed register value, the update pulse with its index, and the mirroring code all become visible one register stage later, just after that same edge. The pulse drops after the following edge.

The bench changes inputs on falling edges and samples results on the next falling edge, which is half a clock after the edge that made them. It then waits one more falling edge to confirm that the pulse has cleared. Expected values come from a bench-side model advanced once per driven write.

// File: rtl/sermap_pkg.sv
package sermap_pkg;

    localparam int REG_W    = 5;
    localparam int NUM_REGS = 4;
    localparam int SEL_W    = $clog2(NUM_REGS);
    localparam int CNT_W    = $clog2(REG_W);

    typedef enum logic [1:0] {
        MIR_TWO_HORZ  = 2'd0,
        MIR_TWO_VERT  = 2'd1,
        MIR_ONE_UPPER = 2'd2,
        MIR_ONE_LOWER = 2'd3
    } mirror_e;

    typedef struct packed {
        logic             valid;
        logic [SEL_W-1:0] idx;
        logic [REG_W-1:0] value;
    } commit_t;

    function automatic mirror_e decode_mirror(input logic [1:0] mode_bits);
        mirror_e m;
        case (mode_bits)
            2'b11:   m = MIR_TWO_HORZ;
            2'b10:   m = MIR_TWO_VERT;
            2'b01:   m = MIR_ONE_UPPER;
            default: m = MIR_ONE_LOWER;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sm_serial_collector.sv
module sm_serial_collector
    import sermap_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int SEL_LSB   = 13,
    parameter int ABORT_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output commit_t           commit_o
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(REG_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [REG_W-1:0] part_q;
    logic [SEL_W-1:0] last_sel_q;

    logic             accept;
    logic             abort;
    logic [SEL_W-1:0] sel;
    logic             sel_changed;
    logic [CNT_W-1:0] base_cnt;
    logic [REG_W-1:0] base_part;
    logic [REG_W-1:0] merged;
    logic             final_bit;

    always_comb begin
        accept      = wr_stb & wr_addr[ADDR_W-1];
        abort       = wr_data[ABORT_BIT];
        sel         = wr_addr[SEL_LSB +: SEL_W];
        sel_changed = (sel != last_sel_q);
        base_cnt    = sel_changed ? '0 : cnt_q;
        base_part   = sel_changed ? '0 : part_q;
        merged      = base_part | (REG_W'(wr_data[0]) << base_cnt);
        final_bit   = (base_cnt == LAST_POS);

        commit_o.valid = accept & ~abort & final_bit;
        commit_o.idx   = sel;
        commit_o.value = merged;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            part_q     <= '0;
            last_sel_q <= '0;
        end else if (accept) begin
            last_sel_q <= sel;
            if (abort || final_bit) begin
                cnt_q  <= '0;
                part_q <= '0;
            end else begin
                cnt_q  <= base_cnt + CNT_W'(1);
                part_q <= merged;
            end
        end
    end

endmodule

// File: rtl/sm_reg_bank.sv
module sm_reg_bank
    import sermap_pkg::*;
#(
    parameter logic [REG_W-1:0] RST_CTRL = 5'h0C
) (
    input  logic                      clk,
    input  logic                      rst,
    input  commit_t                   commit_i,
    output logic [NUM_REGS*REG_W-1:0] regs_o
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [REG_W-1:0] RST_VAL = (i == 0) ? RST_CTRL : '0;
        logic [REG_W-1:0] val_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= RST_VAL;
            end else if (commit_i.valid && commit_i.idx == SEL_W'(i)) begin
                val_q <= commit_i.value;
            end
        end

        assign regs_o[i*REG_W +: REG_W] = val_q;
    end

endmodule

// File: rtl/sm_mirror_decode.sv
module sm_mirror_decode
    import sermap_pkg::*;
(
    input  logic [REG_W-1:0] ctrl_i,
    output logic [1:0]       mirror_o
);

    mirror_e mode;

    always_comb begin
        mode     = decode_mirror(ctrl_i[1:0]);
        mirror_o = mode;
    end

endmodule

// File: rtl/serial_mapper_regs.sv
module serial_mapper_regs
    import sermap_pkg::*;
#(
    parameter int               ADDR_W    = 16,
    parameter int               DATA_W    = 8,
    parameter int               SEL_LSB   = 13,
    parameter int               ABORT_BIT = 7,
    parameter logic [REG_W-1:0] RST_CTRL  = 5'h0C
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_stb,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [NUM_REGS*REG_W-1:0] reg_vec,
    output logic                      upd_pulse,
    output logic [SEL_W-1:0]          upd_index,
    output logic [1:0]                mirror_code
);

    commit_t commit;

    sm_serial_collector #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SEL_LSB   (SEL_LSB),
        .ABORT_BIT (ABORT_BIT)
    ) i_collect (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .commit_o (commit)
    );

    sm_reg_bank #(
        .RST_CTRL (RST_CTRL)
    ) i_bank (
        .clk      (clk),
        .rst      (rst),
        .commit_i (commit),
        .regs_o   (reg_vec)
    );

    sm_mirror_decode i_mirror (
        .ctrl_i   (reg_vec[REG_W-1:0]),
        .mirror_o (mirror_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_pulse <= 1'b0;
            upd_index <= '0;
        end else begin
            upd_pulse <= commit.valid;
            if (commit.valid) begin
                upd_index <= commit.idx;
            end
        end
    end

endmodule

// File: rtl/sm_regs_chk.sv
module sm_regs_chk
    import sermap_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int SEL_LSB   = 13,
    parameter int ABORT_BIT = 7
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_stb,
    input logic [ADDR_W-1:0]         wr_addr,
    input logic [DATA_W-1:0]         wr_data,
    input logic [NUM_REGS*REG_W-1:0] reg_vec,
    input logic                      upd_pulse,
    input logic [SEL_W-1:0]          upd_index,
    input logic [1:0]                mirror_code
);

    // R2
    no_commit_unaccepted_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && wr_addr[ADDR_W-1]) |=> !upd_pulse);

    // R5
    no_commit_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr[ADDR_W-1] && wr_data[ABORT_BIT]) |=> !upd_pulse);

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |=> !upd_pulse);

    // R4
    pulse_index_chk: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |-> (upd_index == $past(wr_addr[SEL_LSB +: SEL_W])));

    // R9
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_pulse |-> (reg_vec == $past(reg_vec)));

    // R8
    mirror_two_chk: assert property (@(posedge clk) disable iff (rst)
        reg_vec[1] |-> (mirror_code == (reg_vec[0] ? 2'd0 : 2'd1)));

    // R8
    mirror_one_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_vec[1] |-> (mirror_code == (reg_vec[0] ? 2'd2 : 2'd3)));

endmodule

bind serial_mapper_regs sm_regs_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SEL_LSB   (SEL_LSB),
    .ABORT_BIT (ABORT_BIT)
) i_chk (.*);

// File: tb/test_serial_mapper_regs.sv
module test_serial_mapper_regs;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [19:0] reg_vec;
    logic        upd_pulse;
    logic [1:0]  upd_index;
    logic [1:0]  mirror_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench-side reference state
    int         m_cnt;
    logic [4:0] m_part;
    logic [1:0] m_last;
    logic [4:0] m_regs [4];
    logic       m_pulse;
    logic [1:0] m_idx;

    serial_mapper_regs i_serial_mapper_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .reg_vec     (reg_vec),
        .upd_pulse   (upd_pulse),
        .upd_index   (upd_index),
        .mirror_code (mirror_code)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [1:0] exp_mirror(input logic [4:0] r0);
        if (r0[1]) return r0[0] ? 2'd0 : 2'd1;
        return r0[0] ? 2'd2 : 2'd3;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt   = 0;
        m_part  = '0;
        m_last  = '0;
        m_regs  = '{5'h0C, 5'h00, 5'h00, 5'h00};
        m_pulse = 1'b0;
        m_idx   = '0;
    endtask

    task automatic model_write(input logic stb, input logic [15:0] a, input logic [7:0] d);
        logic [1:0] sel;
        m_pulse = 1'b0;
        if (stb && a[15]) begin
            sel = a[14:13];
            if (sel != m_last) begin
                m_cnt  = 0;
                m_part = '0;
            end
            m_last = sel;
            if (d[7]) begin
                m_cnt  = 0;
                m_part = '0;
            end else begin
                m_part[m_cnt] = d[0];
                m_cnt++;
                if (m_cnt == 5) begin
                    m_regs[sel] = m_part;
                    m_pulse     = 1'b1;
                    m_idx       = sel;
                    m_cnt       = 0;
                    m_part      = '0;
                end
            end
        end
    endtask

    task automatic check_all();
        check(upd_pulse == m_pulse, "R4 update pulse", 32'(upd_pulse), 32'(m_pulse));
        if (m_pulse)
            check(upd_index == m_idx, "R7 update index", 32'(upd_index), 32'(m_idx));
        for (int i = 0; i < 4; i++)
            check(reg_vec[i*5 +: 5] == m_regs[i], "R9 register value",
                  32'(reg_vec[i*5 +: 5]), 32'(m_regs[i]));
        check(mirror_code == exp_mirror(m_regs[0]), "R8 mirror code",
              32'(mirror_code), 32'(exp_mirror(m_regs[0])));
    endtask

    // drive one cycle of stimulus, then check the outputs after the edge
    task automatic do_write(input logic stb, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_stb  = stb;
        wr_addr = a;
        wr_data = d;
        model_write(stb, a, d);
        @(negedge clk);
        wr_stb = 1'b0;
        check_all();
        @(negedge clk);
        check(upd_pulse == 1'b0, "R7 pulse lasts one clock", 32'(upd_pulse), 32'd0);
    endtask

    function automatic logic [15:0] addr_of(input logic [1:0] sel);
        return {1'b1, sel, 13'($urandom)};
    endfunction

    function automatic logic [7:0] data_of(input logic b);
        logic [7:0] r;
        r    = 8'($urandom);
        r[7] = 1'b0;
        r[0] = b;
        return r;
    endfunction

    task automatic load(input logic [1:0] sel, input logic [4:0] v);
        for (int k = 0; k < 5; k++)
            do_write(1'b1, addr_of(sel), data_of(v[k]));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        check(reg_vec == {5'h00, 5'h00, 5'h00, 5'h0C}, "R1 reset registers",
              32'(reg_vec), 32'h0000C);
        rst = 1'b0;
        @(negedge clk);
        check(reg_vec[4:0] == 5'h0C, "R1 reg0 after reset", 32'(reg_vec[4:0]), 32'h0C);
        check(mirror_code == 2'd3, "R1 mirror after reset", 32'(mirror_code), 32'd3);
        check(upd_pulse == 1'b0, "R1 no pulse after reset", 32'(upd_pulse), 32'd0);

        // R3: least significant bit first
        load(2'd3, 5'b10110);
        check(reg_vec[19:15] == 5'b10110, "R3 bit order", 32'(reg_vec[19:15]), 32'h16);

        // R8: each mirroring pattern through register 0
        for (int p = 0; p < 4; p++) begin
            load(2'd0, {3'b011, 2'(p)});
            check(mirror_code == exp_mirror({3'b011, 2'(p)}), "R8 mirror pattern",
                  32'(mirror_code), 32'(exp_mirror({3'b011, 2'(p)})));
        end

        // R5: abort mid-load, then a fresh five-bit load
        for (int k = 0; k < 3; k++) do_write(1'b1, addr_of(2'd1), data_of(1'b1));
        do_write(1'b1, addr_of(2'd1), 8'hFF);
        for (int k = 0; k < 4; k++) do_write(1'b1, addr_of(2'd1), data_of(1'b0));
        check(upd_pulse == 1'b0 && reg_vec[9:5] == 5'h00, "R5 abort leaves no commit",
              32'(reg_vec[9:5]), 32'h00);
        do_write(1'b1, addr_of(2'd1), data_of(1'b1));
        check(reg_vec[9:5] == 5'b10000, "R5 fresh load after abort",
              32'(reg_vec[9:5]), 32'h10);

        // R6: select change discards a partial load
        for (int k = 0; k < 3; k++) do_write(1'b1, addr_of(2'd2), data_of(1'b1));
        load(2'd1, 5'b00011);
        check(reg_vec[9:5] == 5'b00011 && reg_vec[14:10] == 5'h00,
              "R6 select change restarts", 32'(reg_vec[14:5]), 32'h003);
        // R6: abort write on another select still updates the remembered select
        for (int k = 0; k < 2; k++) do_write(1'b1, addr_of(2'd2), data_of(1'b1));
        do_write(1'b1, addr_of(2'd3), 8'h80);
        load(2'd3, 5'b01001);
        check(reg_vec[19:15] == 5'b01001, "R6 abort write tracks select",
              32'(reg_vec[19:15]), 32'h09);

        // R2: writes without strobe or without address bit 15 are ignored
        for (int k = 0; k < 2; k++) do_write(1'b1, addr_of(2'd2), data_of(1'b1));
        do_write(1'b1, 16'h2000, data_of(1'b0));
        do_write(1'b0, addr_of(2'd1), 8'h80);
        do_write(1'b0, addr_of(2'd3), data_of(1'b0));
        for (int k = 0; k < 3; k++) do_write(1'b1, addr_of(2'd2), data_of(1'b0));
        check(reg_vec[14:10] == 5'b00011, "R2 ignored writes keep partial load",
              32'(reg_vec[14:10]), 32'h03);

        // constrained random traffic
        for (int n = 0; n < 1500; n++) begin
            logic [1:0]  sel;
            logic [15:0] a;
            logic [7:0]  d;
            logic        stb;
            sel = ($urandom_range(0, 7) == 0) ? 2'($urandom) : m_last;
            a   = addr_of(sel);
            if ($urandom_range(0, 9) == 0) a[15] = 1'b0;
            stb = ($urandom_range(0, 9) != 0);
            d   = data_of(1'($urandom));
            if ($urandom_range(0, 15) == 0) d[7] = 1'b1;
            do_write(stb, a, d);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule